// File: doc/BRIEF.md
# Auxiliary Processor Power Sequencer

This block brings a small always-on helper processor up and down under control of one 32-bit configuration word. A start request from the power controller opens the processor clock and holds the processor in reset. Reset is released after a programmable number of cycles. A one-cycle start interrupt follows after a second programmable count, and never before reset has been released. A shutdown request, written into the configuration word, starts a third countdown that ends by gating the clock and putting the processor back into reset. A shutdown that arrives while the start sequence is still running cancels that sequence.

The same word also carries several other controls. One bit keeps the clock running whatever the sequencer does. One bit holds the processor in reset. A select bit chooses which of the two processor types is active. A source bit chooses which core's done line is honoured. A done bit halts the processor and fires a wake-timer start pulse. A write-only bit sends the processor a single-cycle software interrupt. All outputs are registered. Reset is synchronous and active high.

Top module: `aux_cpu_seq`

## Requirements
- R1: After reset, the register reads 0x008A0810 (reset-release count 8, interrupt count 16, gate count 40, type select 1). `cpu_rst_o` is 1 and `sel_fsm_o` is 1. `cpu_clk_en_o`, `start_irq_o`, `sw_irq_o`, `cpu_halt_o` and `wake_go_o` are 0.
- R2: Bits 24:0 read back as last written from the edge of the write onward. Bit 25 reads the halt state. Bits 31:26 read 0.
- R3: Let t0 be the edge at which the idle sequencer samples `start_req_i` high. `cpu_clk_en_o` is 1 after t0, and `cpu_rst_o` falls after edge t0+R+1, where R is bits 6:1.
- R4: `start_irq_o` is high for exactly the one cycle after edge t0+max(I, R+1)+1, where I is bits 12:7. It therefore always comes after reset release.
- R5: A write with bit 13 = 1 at edge E, while not idle, makes `cpu_clk_en_o` fall and `cpu_rst_o` rise after edge E+G+1, where G is bits 21:14. If the write lands during the start sequence, no start interrupt is issued.
- R6: `start_req_i` has no effect unless the sequencer is idle. While running, reset stays released and no further start interrupt appears.
- R7: Bit 0 = 1 drives `cpu_clk_en_o` high from the second edge after the write, even when idle. Clearing it lets the sequencer decide again from the second edge.
- R8: Bit 22 = 1 drives `cpu_rst_o` high from the second edge after the write, whatever the sequence state. Clearing it returns reset to the sequencer's value.
- R9: `sel_fsm_o` equals bit 23 from the write edge onward (1 = state-machine core, 0 = RISC-V core).
- R10: A halt event is a write with bit 25 = 1, or a high sample of the selected done input (bit 24 = 1 selects `rv_done_i`, 0 selects `fsm_done_i`). It sets `cpu_halt_o` after that edge, and `wake_go_o` pulses for one cycle when the halt becomes set. The input that is not selected is ignored. A start clears the halt at t0.
- R11: A write with bit 26 = 1 drives `sw_irq_o` high for exactly the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 32 | Configuration write data |
| reg_rdata | output | 32 | Configuration read data |
| start_req_i | input | 1 | Start request from the power controller |
| rv_done_i | input | 1 | Done line from the RISC-V core |
| fsm_done_i | input | 1 | Done line from the state-machine core |
| cpu_rst_o | output | 1 | Processor reset, high = held |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| start_irq_o | output | 1 | One-cycle start interrupt |
| sw_irq_o | output | 1 | One-cycle software interrupt |
| cpu_halt_o | output | 1 | Processor halt |
| wake_go_o | output | 1 | One-cycle wake-timer start |
| sel_fsm_o | output | 1 | Active processor type |

## Verification
Event edges are counted from the edge that samples the stimulus.
- Register fields, the type select and the halt are visible right after that edge.
- The software interrupt and the wake pulse also appear after that edge and last one cycle.
- Force and hold act one edge later.
- Reset release falls at R+1 edges, the start interrupt at max(I, R+1)+1 edges, and clock gating at G+1 edges.

The bench drives at falling edges and samples at each following falling edge. It records the first cycle in which each output changes, and compares that cycle number with the one computed from the programmed counts. It sweeps R over 0..5 and I over 0..9, and G over small values and both limits.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  localparam int REG_W   = 32;
  localparam int RDLY_W  = 6;
  localparam int IDLY_W  = 6;
  localparam int GDLY_W  = 8;
  // bit layout of the configuration word (software decodes it)
  localparam int B_FORCE = 0;
  localparam int B_RDLY  = B_FORCE + 1;
  localparam int B_IDLY  = B_RDLY + RDLY_W;
  localparam int B_SHUT  = B_IDLY + IDLY_W;
  localparam int B_GDLY  = B_SHUT + 1;
  localparam int B_HOLD  = B_GDLY + GDLY_W;
  localparam int B_SEL   = B_HOLD + 1;
  localparam int B_DSRC  = B_SEL + 1;
  localparam int B_HALT  = B_DSRC + 1;
  localparam int B_SWI   = B_HALT + 1;
  localparam logic [REG_W-1:0] REG_RST = 32'h008A_0810;

  typedef enum logic [1:0] {SQ_IDLE, SQ_BOOT, SQ_RUN, SQ_STOP} sq_state_t;

  typedef struct packed {
    logic              force_clk;
    logic [RDLY_W-1:0] rdly;
    logic [IDLY_W-1:0] idly;
    logic [GDLY_W-1:0] gdly;
    logic              hold_rst;
    logic              sel_fsm;
    logic              done_rv;
  } seq_cfg_t;
endpackage

// File: rtl/aux_seq_cfg.sv
module aux_seq_cfg
  import aux_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             halt_i,
  output seq_cfg_t         cfg_o,
  output logic [REG_W-1:0] rdata_o,
  output logic             shut_evt_o,
  output logic             halt_wr_o,
  output logic             sw_irq_o
);
  localparam int FLD_W = B_DSRC + 1;
  localparam int PAD_W = REG_W - B_HALT - 1;

  logic [FLD_W-1:0] fld_q;
  logic             swi_q;
  logic             unused_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q <= REG_RST[FLD_W-1:0];
      swi_q <= 1'b0;
    end else begin
      if (we) fld_q <= wdata[FLD_W-1:0];
      swi_q <= we & wdata[B_SWI];
    end
  end

  assign unused_hi  = ^wdata[REG_W-1:B_SWI+1];
  assign rdata_o    = {{PAD_W{1'b0}}, halt_i, fld_q};
  assign shut_evt_o = we & wdata[B_SHUT];
  assign halt_wr_o  = we & wdata[B_HALT];
  assign sw_irq_o   = swi_q;

  assign cfg_o.force_clk = fld_q[B_FORCE];
  assign cfg_o.rdly      = fld_q[B_RDLY +: RDLY_W];
  assign cfg_o.idly      = fld_q[B_IDLY +: IDLY_W];
  assign cfg_o.gdly      = fld_q[B_GDLY +: GDLY_W];
  assign cfg_o.hold_rst  = fld_q[B_HOLD];
  assign cfg_o.sel_fsm   = fld_q[B_SEL];
  assign cfg_o.done_rv   = fld_q[B_DSRC];

  AST_SWI_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    swi_q |-> $past(we && wdata[B_SWI])) else $error("sw irq without write"); // R11
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> $stable(fld_q)) else $error("fields changed without write"); // R2
endmodule

// File: rtl/aux_seq_fsm.sv
module aux_seq_fsm
  import aux_seq_pkg::*;
#(
  parameter int RW = RDLY_W,
  parameter int IW = IDLY_W,
  parameter int GW = GDLY_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic          shut_evt,
  input  logic [RW-1:0] rdly,
  input  logic [IW-1:0] idly,
  input  logic [GW-1:0] gdly,
  input  logic          force_clk,
  input  logic          hold_rst,
  output logic          cpu_rst_o,
  output logic          clk_en_o,
  output logic          start_irq_o,
  output logic          start_go_o
);
  localparam int EW = ((RW > IW) ? RW : IW) + 1;

  sq_state_t     state_q, state_d;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic [GW-1:0] gcnt_q, gcnt_d;
  logic          srst_q, srst_d;
  logic          irq_d;
  logic          cpu_rst_q, clk_en_q, irq_q;
  logic [EW-1:0] rel_pt, irq_pt, irq_tgt;

  // interrupt point: programmed count, but never before the cycle after release
  assign rel_pt  = EW'(rdly) + EW'(1);
  assign irq_pt  = EW'(idly);
  assign irq_tgt = (irq_pt > rel_pt) ? irq_pt : rel_pt;

  always_comb begin
    state_d    = state_q;
    ecnt_d     = ecnt_q;
    gcnt_d     = gcnt_q;
    srst_d     = srst_q;
    irq_d      = 1'b0;
    start_go_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_req) begin
          state_d    = SQ_BOOT;
          ecnt_d     = '0;
          srst_d     = 1'b1;
          start_go_o = 1'b1;
        end
      end
      SQ_BOOT: begin
        if (shut_evt) begin
          state_d = SQ_STOP;
          gcnt_d  = '0;
        end else begin
          ecnt_d = ecnt_q + EW'(1);
          if (ecnt_q == EW'(rdly)) srst_d = 1'b0;
          if (ecnt_q == irq_tgt) begin
            irq_d   = 1'b1;
            state_d = SQ_RUN;
          end
        end
      end
      SQ_RUN: begin
        if (shut_evt) begin
          state_d = SQ_STOP;
          gcnt_d  = '0;
        end
      end
      SQ_STOP: begin
        gcnt_d = gcnt_q + GW'(1);
        if (gcnt_q == gdly) begin
          state_d = SQ_IDLE;
          srst_d  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      ecnt_q    <= '0;
      gcnt_q    <= '0;
      srst_q    <= 1'b1;
      cpu_rst_q <= 1'b1;
      clk_en_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      ecnt_q    <= ecnt_d;
      gcnt_q    <= gcnt_d;
      srst_q    <= srst_d;
      cpu_rst_q <= srst_d | hold_rst;
      clk_en_q  <= (state_d != SQ_IDLE) | force_clk;
      irq_q     <= irq_d;
    end
  end

  assign cpu_rst_o   = cpu_rst_q;
  assign clk_en_o    = clk_en_q;
  assign start_irq_o = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q) else $error("start irq longer than one cycle"); // R4
  AST_IRQ_AFTER_REL: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> !srst_q) else $error("start irq before reset release"); // R4
  AST_FORCE_CLK: assert property (@(posedge clk) disable iff (rst)
    force_clk |=> clk_en_q) else $error("clock not forced on"); // R7
  AST_HOLD_RST: assert property (@(posedge clk) disable iff (rst)
    hold_rst |=> cpu_rst_q) else $error("reset hold ignored"); // R8
  AST_GATE_WITH_RST: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_en_q) |-> cpu_rst_q) else $error("clock gated with reset released"); // R5
endmodule

// File: rtl/aux_seq_halt.sv
module aux_seq_halt (
  input  logic clk,
  input  logic rst,
  input  logic halt_wr,
  input  logic done_rv_sel,
  input  logic rv_done_i,
  input  logic fsm_done_i,
  input  logic start_go,
  output logic halt_o,
  output logic wake_go_o
);
  logic done_src, evt;
  logic halt_q, wake_q;

  assign done_src = done_rv_sel ? rv_done_i : fsm_done_i;
  assign evt      = halt_wr | done_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      halt_q <= start_go ? 1'b0 : (halt_q | evt);
      wake_q <= evt & ~halt_q & ~start_go;
    end
  end

  assign halt_o    = halt_q;
  assign wake_go_o = wake_q;

  AST_WAKE_WITH_HALT: assert property (@(posedge clk) disable iff (rst)
    wake_q |-> halt_q) else $error("wake pulse without halt"); // R10
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wake_q |=> !wake_q) else $error("wake pulse longer than one cycle"); // R10
endmodule

// File: rtl/aux_cpu_seq.sv
module aux_cpu_seq
  import aux_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             start_req_i,
  input  logic             rv_done_i,
  input  logic             fsm_done_i,
  output logic             cpu_rst_o,
  output logic             cpu_clk_en_o,
  output logic             start_irq_o,
  output logic             sw_irq_o,
  output logic             cpu_halt_o,
  output logic             wake_go_o,
  output logic             sel_fsm_o
);
  seq_cfg_t cfg;
  logic     shut_evt, halt_wr, start_go, halt;

  aux_seq_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .wdata      (reg_wdata),
    .halt_i     (halt),
    .cfg_o      (cfg),
    .rdata_o    (reg_rdata),
    .shut_evt_o (shut_evt),
    .halt_wr_o  (halt_wr),
    .sw_irq_o   (sw_irq_o)
  );

  aux_seq_fsm #(.RW(RDLY_W), .IW(IDLY_W), .GW(GDLY_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req_i),
    .shut_evt    (shut_evt),
    .rdly        (cfg.rdly),
    .idly        (cfg.idly),
    .gdly        (cfg.gdly),
    .force_clk   (cfg.force_clk),
    .hold_rst    (cfg.hold_rst),
    .cpu_rst_o   (cpu_rst_o),
    .clk_en_o    (cpu_clk_en_o),
    .start_irq_o (start_irq_o),
    .start_go_o  (start_go)
  );

  aux_seq_halt u_halt (
    .clk         (clk),
    .rst         (rst),
    .halt_wr     (halt_wr),
    .done_rv_sel (cfg.done_rv),
    .rv_done_i   (rv_done_i),
    .fsm_done_i  (fsm_done_i),
    .start_go    (start_go),
    .halt_o      (halt),
    .wake_go_o   (wake_go_o)
  );

  assign cpu_halt_o = halt;
  assign sel_fsm_o  = cfg.sel_fsm;
endmodule

// File: tb/aux_cpu_seq_bench.sv
`timescale 1ns/1ps
module aux_cpu_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        start_req_i = 1'b0, rv_done_i = 1'b0, fsm_done_i = 1'b0;
  logic        cpu_rst_o, cpu_clk_en_o, start_irq_o, sw_irq_o, cpu_halt_o, wake_go_o, sel_fsm_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  aux_cpu_seq u_aux_cpu_seq (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_req_i(start_req_i), .rv_done_i(rv_done_i), .fsm_done_i(fsm_done_i),
    .cpu_rst_o(cpu_rst_o), .cpu_clk_en_o(cpu_clk_en_o), .start_irq_o(start_irq_o),
    .sw_irq_o(sw_irq_o), .cpu_halt_o(cpu_halt_o), .wake_go_o(wake_go_o), .sel_fsm_o(sel_fsm_o)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit f, int r, int i, int g, bit hold, bit sel, bit src, bit shut);
    return 32'(f) | (32'(r) << 1) | (32'(i) << 7) | (32'(shut) << 13) | (32'(g) << 14)
         | (32'(hold) << 22) | (32'(sel) << 23) | (32'(src) << 24);
  endfunction

  // write lands on the edge between the two falling edges
  task automatic wr(logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic do_start();
    @(negedge clk); start_req_i = 1'b1;
    @(negedge clk); start_req_i = 1'b0;
  endtask

  task automatic pulse_done(bit rv);
    @(negedge clk); if (rv) rv_done_i = 1'b1; else fsm_done_i = 1'b1;
    @(negedge clk); rv_done_i = 1'b0; fsm_done_i = 1'b0;
  endtask

  // start with counts r,i, measure release and interrupt cycles, then shut down with g
  task automatic run_cycle(int r, int i, int g);
    int rel_k = -1, irq_k = -1, irq_n = 0, gate_k = -1;
    int exp_irq;
    wr(mk(0, r, i, g, 0, 1, 0, 0));
    do_start();
    chk("R3 clock on at start", 32'(cpu_clk_en_o), 1);
    chk("R3 reset held at start", 32'(cpu_rst_o), 1);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (rel_k < 0 && !cpu_rst_o) rel_k = k;
      if (start_irq_o) begin irq_n++; if (irq_k < 0) irq_k = k; end
    end
    exp_irq = ((i > r + 1) ? i : r + 1) + 1;
    chk("R3 release cycle", 32'(rel_k), 32'(r + 1));
    chk("R4 irq cycle", 32'(irq_k), 32'(exp_irq));
    chk("R4 irq count", 32'(irq_n), 1);
    wr(mk(0, r, i, g, 0, 1, 0, 1));
    for (int k = 1; k <= g + 3; k++) begin
      @(negedge clk);
      if (gate_k < 0 && !cpu_clk_en_o) begin
        gate_k = k;
        chk("R5 reset at gate", 32'(cpu_rst_o), 1);
      end
    end
    chk("R5 gate cycle", 32'(gate_k), 32'(g + 1));
  endtask

  initial begin
    int gl[5] = '{0, 1, 2, 40, 255};
    int irq_n, gate_k;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reg", reg_rdata, 32'h008A0810);
    chk("R1 rst", 32'(cpu_rst_o), 1);
    chk("R1 clk", 32'(cpu_clk_en_o), 0);
    chk("R1 irqs", 32'({start_irq_o, sw_irq_o, cpu_halt_o, wake_go_o}), 0);
    chk("R1 sel", 32'(sel_fsm_o), 1);

    // R2 / R9 / R8 / R7 / R11 register behaviour
    wr(32'hF15A5A5A);
    chk("R2 readback A", reg_rdata, 32'h015A5A5A);
    chk("R9 sel 0", 32'(sel_fsm_o), 0);
    chk("R11 no swi", 32'(sw_irq_o), 0);
    wr(32'h04A5A5A5);
    chk("R2 readback B", reg_rdata, 32'h00A5A5A5);
    chk("R9 sel 1", 32'(sel_fsm_o), 1);
    chk("R11 swi pulse", 32'(sw_irq_o), 1);
    chk("R7 force not yet", 32'(cpu_clk_en_o), 0);
    @(negedge clk);
    chk("R11 swi ends", 32'(sw_irq_o), 0);
    chk("R7 force clk", 32'(cpu_clk_en_o), 1);
    wr(32'h008A0810);
    @(negedge clk);
    chk("R7 force cleared", 32'(cpu_clk_en_o), 0);

    // R3 / R4 / R5 sweeps
    for (int r = 0; r <= 5; r++)
      for (int i = 0; i <= 9; i++)
        run_cycle(r, i, (r * 3 + i) % 5);
    foreach (gl[j]) run_cycle(2, 3, gl[j]);

    // R6 and R8 while running
    wr(mk(0, 2, 4, 3, 0, 1, 0, 0));
    do_start();
    repeat (10) @(negedge clk);
    irq_n = 0;
    do_start();
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (start_irq_o) irq_n++;
      if (cpu_rst_o) irq_n += 100;
    end
    chk("R6 start ignored when running", 32'(irq_n), 0);
    wr(mk(0, 2, 4, 3, 1, 1, 0, 0));
    chk("R8 hold not yet", 32'(cpu_rst_o), 0);
    @(negedge clk);
    chk("R8 hold reset", 32'(cpu_rst_o), 1);
    wr(mk(0, 2, 4, 3, 0, 1, 0, 0));
    @(negedge clk);
    chk("R8 hold released", 32'(cpu_rst_o), 0);
    wr(mk(0, 2, 4, 3, 0, 1, 0, 1));
    repeat (6) @(negedge clk);
    chk("R5 gated after run", 32'(cpu_clk_en_o), 0);

    // R5 abort during start
    wr(mk(0, 5, 9, 3, 0, 1, 0, 0));
    do_start();
    @(negedge clk);
    irq_n = 0; gate_k = -1;
    wr(mk(0, 5, 9, 3, 0, 1, 0, 1));
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (start_irq_o) irq_n++;
      if (gate_k < 0 && !cpu_clk_en_o) gate_k = k;
    end
    chk("R5 abort no irq", 32'(irq_n), 0);
    chk("R5 abort gate cycle", 32'(gate_k), 4);

    // R10 halt and done source
    pulse_done(1);
    chk("R10 unselected rv done ignored", 32'(cpu_halt_o), 0);
    pulse_done(0);
    chk("R10 fsm done halts", 32'(cpu_halt_o), 1);
    chk("R10 wake pulse", 32'(wake_go_o), 1);
    chk("R2 halt readback", 32'(reg_rdata[25]), 1);
    @(negedge clk);
    chk("R10 wake single", 32'(wake_go_o), 0);
    wr(mk(0, 1, 1, 1, 0, 1, 1, 0));
    do_start();
    chk("R10 start clears halt", 32'(cpu_halt_o), 0);
    pulse_done(0);
    chk("R10 unselected fsm done ignored", 32'(cpu_halt_o), 0);
    pulse_done(1);
    chk("R10 rv done halts", 32'(cpu_halt_o), 1);
    wr(mk(0, 1, 1, 1, 0, 1, 1, 1));
    repeat (4) @(negedge clk);
    do_start();
    chk("R10 halt cleared again", 32'(cpu_halt_o), 0);
    wr(mk(0, 1, 1, 1, 0, 1, 1, 0) | 32'h02000000);
    chk("R10 written halt", 32'(cpu_halt_o), 1);
    chk("R10 written wake", 32'(wake_go_o), 1);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule